// File: doc/BRIEF.md
# External Data Access Sequencer with Stretchable Strobes

This block turns one data-memory request from a processor core into a timed access. The core's time unit is the machine cycle, which is four clock periods. Each request carries a 16-bit address, a read/write flag and a write byte. Depending on a configuration bit and the address, the access goes to a 1 KB on-chip RAM or to a multiplexed external bus. The external bus shares one byte lane for the low address and the data, and has a separate high-address byte.

An external access starts with an address-latch phase. The read or write strobe follows, and its width comes from a 3-bit stretch setting, so slow memories can be served without wait-state logic outside the block. The read byte is taken in at the edge where the strobe ends, and a one-clock completion pulse is raised at the same point. Internal accesses have a fixed length and leave the external bus idle. The stretch setting and the on-chip window enable live in a small configuration register that the core writes.

Top module: `xdata_seq`

## Requirements
- R1: An external access lasts 4*(N+2) clocks, counted from the accepting clock edge to the edge that raises `done`. N is the stretch setting, 0 to 7, and `busy` is high for exactly those clocks.
- R2: After reset the stretch setting is 1 and the on-chip window is disabled. Any address, including 0000h, then runs a 12-clock external access.
- R3: During an external access exactly one strobe goes low: `bus_rd_n` for a read, `bus_wr_n` for a write. It stays low for 4*(N+1) clocks ending at the completion edge. The two strobes are never low together.
- R4: The first two clocks of an external access hold `bus_ale` high. During those clocks `bus_ad_out` carries address bits 7:0, `bus_addr_hi` carries bits 15:8 and `bus_ad_oe` is 1. During a read strobe `bus_ad_oe` is 0.
- R5: With the window enabled (`cfg_iram_en`=1), addresses 0000h–03FFh are served by the on-chip RAM in 8 clocks whatever the stretch. During such an access `bus_ale` stays 0 and both strobes stay high.
- R6: Addresses 0400h and above always run an external access, even with the window enabled.
- R7: Read data appears on `rdata` in the same clock as the one-clock `done` pulse. `rdata` changes only in a `done` clock.
- R8: During a write strobe the write byte is driven on `bus_ad_out` with `bus_ad_oe`=1.
- R9: A request is accepted only while `busy` is 0. A request raised while `busy` is 1 is ignored and produces no access and no `done`.
- R10: A configuration write on the same edge that accepts a request affects only later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load the configuration register |
| cfg_stretch | input | 3 | New stretch setting N |
| cfg_iram_en | input | 1 | New on-chip window enable |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write byte |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Read byte, valid with `done` |
| bus_ale | output | 1 | External address-latch enable |
| bus_rd_n | output | 1 | External read strobe, active low |
| bus_wr_n | output | 1 | External write strobe, active low |
| bus_addr_hi | output | 8 | External address bits 15:8 |
| bus_ad_out | output | 8 | Multiplexed address/data lane, outgoing |
| bus_ad_oe | output | 1 | Drive enable for `bus_ad_out` |
| bus_ad_in | input | 8 | Multiplexed lane, incoming read data |

## Verification
Two pairs of functions can fall on the same clock edge. The first pair is a configuration write and the acceptance of a request. The bench drives both on one edge and checks that the access length and strobe width follow the old stretch setting while the next access follows the new one. The second pair is the `done` clock of one access and the acceptance of the next. The driver issues each request in the `done` clock, so accesses run back to back. The scoreboard then checks that no clock of either access is lost or merged into the other.

// File: rtl/xdata_pkg.sv
package xdata_pkg;

    localparam int ADDR_W      = 16;
    localparam int DATA_W      = 8;
    localparam int CLK_PER_MC  = 4;
    localparam int STRETCH_W   = 3;
    localparam int IRAM_AW     = 10;
    localparam int INT_MC      = 2;
    localparam int BASE_MC     = 2;
    localparam int ALE_CLKS    = 2;
    localparam int STRETCH_RST = 1;
    localparam int MAX_CLKS    = CLK_PER_MC * (BASE_MC + (1 << STRETCH_W) - 1);
    localparam int CNT_W       = $clog2(MAX_CLKS);

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_INT  = 2'd1,
        SEQ_EXT  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } xreq_t;

    typedef struct packed {
        logic ale;
        logic rd_act;
        logic wr_act;
        logic drive;
        logic sel_data;
    } bus_phase_t;

    function automatic logic hits_window(input logic [ADDR_W-1:0] a, input logic en);
        return en && ((a >> IRAM_AW) == '0);
    endfunction

    function automatic logic [CNT_W-1:0] last_count(input logic is_int,
                                                    input logic [STRETCH_W-1:0] n);
        int mc;
        mc = is_int ? INT_MC : (BASE_MC + int'(n));
        return CNT_W'(mc * CLK_PER_MC - 1);
    endfunction

endpackage

// File: rtl/xdata_ctrl.sv
module xdata_ctrl
    import xdata_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 start_int,
    input  logic [STRETCH_W-1:0] stretch,
    output seq_state_e           state,
    output logic [CNT_W-1:0]     cnt,
    output logic                 last
);
    logic [CNT_W-1:0] last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SEQ_IDLE;
            cnt    <= '0;
            last_q <= '0;
        end else begin
            unique case (state)
                SEQ_IDLE: begin
                    if (start) begin
                        state  <= start_int ? SEQ_INT : SEQ_EXT;
                        cnt    <= '0;
                        last_q <= last_count(start_int, stretch);
                    end
                end
                default: begin
                    if (cnt == last_q) begin
                        state <= SEQ_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    assign last = (state != SEQ_IDLE) && (cnt == last_q);

    // R1: counter never runs past the length chosen at acceptance
    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (rst)
        (state != SEQ_IDLE) |-> (cnt <= last_q));

    // R1: an access can only leave through its final clock
    p_exit_last_r1: assert property (@(posedge clk) disable iff (rst)
        ((state != SEQ_IDLE) && !last) |=> (state == $past(state)));

    // R5: internal accesses are fixed length
    p_int_len_r5: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_INT) |-> (last_q == CNT_W'(INT_MC * CLK_PER_MC - 1)));
endmodule

// File: rtl/xdata_phase.sv
module xdata_phase
    import xdata_pkg::*;
(
    input  seq_state_e       state,
    input  logic [CNT_W-1:0] cnt,
    input  logic             write,
    output bus_phase_t       ph
);
    localparam logic [CNT_W-1:0] ALE_END   = CNT_W'(ALE_CLKS);
    localparam logic [CNT_W-1:0] STROBE_AT = CNT_W'(CLK_PER_MC);

    logic ext;
    assign ext = (state == SEQ_EXT);

    always_comb begin
        ph          = '0;
        ph.ale      = ext && (cnt < ALE_END);
        ph.rd_act   = ext && !write && (cnt >= STROBE_AT);
        ph.wr_act   = ext &&  write && (cnt >= STROBE_AT);
        ph.sel_data = ext && (cnt >= ALE_END);
        ph.drive    = ph.ale || (ph.sel_data && write);
    end
endmodule

// File: rtl/xdata_iram.sv
module xdata_iram
    import xdata_pkg::*;
(
    input  logic               clk,
    input  logic               we,
    input  logic               re,
    input  logic [IRAM_AW-1:0] addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata
);
    localparam int DEPTH = 1 << IRAM_AW;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        if (re) rdata <= mem[addr];
    end
endmodule

// File: rtl/xdata_seq.sv
module xdata_seq
    import xdata_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [STRETCH_W-1:0] cfg_stretch,
    input  logic                 cfg_iram_en,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic                 busy,
    output logic                 done,
    output logic [DATA_W-1:0]    rdata,
    output logic                 bus_ale,
    output logic                 bus_rd_n,
    output logic                 bus_wr_n,
    output logic [7:0]           bus_addr_hi,
    output logic [7:0]           bus_ad_out,
    output logic                 bus_ad_oe,
    input  logic [7:0]           bus_ad_in
);
    logic [STRETCH_W-1:0] stretch_q;
    logic                 iram_en_q;
    xreq_t                req_q;
    seq_state_e           state;
    logic [CNT_W-1:0]     cnt;
    logic                 last;
    logic                 accept;
    logic                 start_int;
    bus_phase_t           ph;
    logic [DATA_W-1:0]    iram_q;
    logic [DATA_W-1:0]    rdata_q;
    logic                 done_q;

    assign busy      = (state != SEQ_IDLE);
    assign accept    = req_valid && !busy;
    assign start_int = hits_window(req_addr, iram_en_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            stretch_q <= STRETCH_W'(STRETCH_RST);
            iram_en_q <= 1'b0;
        end else if (cfg_we) begin
            stretch_q <= cfg_stretch;
            iram_en_q <= cfg_iram_en;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else if (accept) begin
            req_q.write <= req_write;
            req_q.addr  <= req_addr;
            req_q.wdata <= req_wdata;
        end
    end

    xdata_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (accept),
        .start_int (start_int),
        .stretch   (stretch_q),
        .state     (state),
        .cnt       (cnt),
        .last      (last)
    );

    xdata_phase u_phase (
        .state (state),
        .cnt   (cnt),
        .write (req_q.write),
        .ph    (ph)
    );

    xdata_iram u_iram (
        .clk   (clk),
        .we    ((state == SEQ_INT) && last && req_q.write),
        .re    ((state == SEQ_INT) && (cnt == '0)),
        .addr  (req_q.addr[IRAM_AW-1:0]),
        .wdata (req_q.wdata),
        .rdata (iram_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= last;
            if (last && !req_q.write)
                rdata_q <= (state == SEQ_INT) ? iram_q : bus_ad_in;
        end
    end

    assign done        = done_q;
    assign rdata       = rdata_q;
    assign bus_ale     = ph.ale;
    assign bus_rd_n    = !ph.rd_act;
    assign bus_wr_n    = !ph.wr_act;
    assign bus_ad_oe   = ph.drive;
    assign bus_addr_hi = (state == SEQ_EXT) ? req_q.addr[ADDR_W-1:ADDR_W-8] : 8'h00;
    assign bus_ad_out  = !ph.drive   ? 8'h00 :
                         ph.sel_data ? req_q.wdata : req_q.addr[7:0];

    // R2: configuration comes out of reset with stretch 1 and the window off
    p_reset_cfg_r2: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (stretch_q == STRETCH_W'(STRETCH_RST)) && !iram_en_q);

    // R3: the two strobes are never active together
    p_strobe_excl_r3: assert property (@(posedge clk) disable iff (rst)
        !(!bus_rd_n && !bus_wr_n));

    // R4: address latch phase and strobe phase never overlap
    p_ale_no_strobe_r4: assert property (@(posedge clk) disable iff (rst)
        bus_ale |-> (bus_rd_n && bus_wr_n && bus_ad_oe));

    // R4: lane released while the read strobe is active
    p_rd_release_r4: assert property (@(posedge clk) disable iff (rst)
        !bus_rd_n |-> !bus_ad_oe);

    // R5: internal accesses leave the external bus quiet
    p_int_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_INT) |-> (!bus_ale && bus_rd_n && bus_wr_n));

    // R7: done is a single-clock pulse
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7: read data moves only with done
    p_rdata_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(rdata) |-> done);

    // R9: a request under way is not overwritten by a new one
    p_busy_ignore_r9: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(req_q));
endmodule

// File: tb/sim_xdata_seq.sv
`timescale 1ns/1ps
module sim_xdata_seq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_stretch = '0;
    logic       cfg_iram_en = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic       busy, done;
    logic [7:0] rdata;
    logic       bus_ale, bus_rd_n, bus_wr_n, bus_ad_oe;
    logic [7:0] bus_addr_hi, bus_ad_out;
    logic [7:0] bus_ad_in = '0;

    always #2.5 clk = ~clk;

    xdata_seq u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_stretch(cfg_stretch),
        .cfg_iram_en(cfg_iram_en), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rdata(rdata), .bus_ale(bus_ale), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
        .bus_addr_hi(bus_addr_hi), .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe),
        .bus_ad_in(bus_ad_in)
    );

    typedef struct {
        logic        write;
        logic [15:0] addr;
        logic [7:0]  wdata;
        int          len;
        int          strobe;
        int          ale;
        logic [7:0]  exp_rd;
        string       tag;
    } item_t;

    item_t q[$];
    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int         b_st = 1;
    bit         b_en = 0;
    logic [7:0] ref_ext [int];
    logic [7:0] ref_int [int];
    logic [7:0] mdl_ext [int];
    logic [15:0] lat = '0;

    function automatic logic [7:0] dflt(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // external memory model on the multiplexed bus
    always @(posedge clk) begin
        if (bus_ale) lat <= {bus_addr_hi, bus_ad_out};
        if (!bus_wr_n) mdl_ext[int'(lat)] = bus_ad_out;
    end
    always @(negedge clk)
        bus_ad_in <= mdl_ext.exists(int'(lat)) ? mdl_ext[int'(lat)] : dflt(lat);

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic issue(input logic wr, input logic [15:0] a, input logic [7:0] d,
                         input string tag, input bit with_cfg = 0,
                         input int new_st = 0, input bit new_en = 0);
        item_t it;
        bit is_int;
        wait_idle();
        is_int    = b_en && (a < 16'h0400);
        it.write  = wr;
        it.addr   = a;
        it.wdata  = d;
        it.tag    = tag;
        it.len    = is_int ? 8 : 4 * (b_st + 2);
        it.strobe = is_int ? 0 : 4 * (b_st + 1);
        it.ale    = is_int ? 0 : 2;
        it.exp_rd = 8'h00;
        if (wr) begin
            if (is_int) ref_int[int'(a)] = d; else ref_ext[int'(a)] = d;
        end else if (is_int) begin
            it.exp_rd = ref_int[int'(a)];
        end else begin
            it.exp_rd = ref_ext.exists(int'(a)) ? ref_ext[int'(a)] : dflt(a);
        end
        q.push_back(it);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        if (with_cfg) begin
            cfg_we = 1'b1; cfg_stretch = 3'(new_st); cfg_iram_en = new_en;
        end
        @(negedge clk);
        req_valid = 1'b0; cfg_we = 1'b0;
        if (with_cfg) begin b_st = new_st; b_en = new_en; end
    endtask

    task automatic set_cfg(input int st, input bit en);
        wait_idle();
        cfg_we = 1'b1; cfg_stretch = 3'(st); cfg_iram_en = en;
        @(negedge clk);
        cfg_we = 1'b0;
        b_st = st; b_en = en;
    endtask

    // monitor and scoreboard
    int busy_n = 0, rd_n_cnt = 0, wr_n_cnt = 0, ale_n = 0, addr_err = 0, lane_err = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (done) begin
                if (q.size() == 0) begin
                    check(0, "R9", "done with no request pending", 1, 0);
                end else begin
                    item_t it;
                    it = q.pop_front();
                    check(busy_n == it.len, "R1", {it.tag, " access length"}, busy_n, it.len);
                    check((it.write ? wr_n_cnt : rd_n_cnt) == it.strobe, "R3",
                          {it.tag, " strobe width"}, it.write ? wr_n_cnt : rd_n_cnt, it.strobe);
                    check((it.write ? rd_n_cnt : wr_n_cnt) == 0, "R3",
                          {it.tag, " wrong strobe"}, it.write ? rd_n_cnt : wr_n_cnt, 0);
                    check(ale_n == it.ale, "R4", {it.tag, " ale width"}, ale_n, it.ale);
                    check(addr_err == 0, "R4", {it.tag, " latched address"}, addr_err, 0);
                    check(lane_err == 0, "R8", {it.tag, " lane drive"}, lane_err, 0);
                    check(!busy, "R1", {it.tag, " busy low with done"}, busy, 0);
                    if (!it.write)
                        check(rdata == it.exp_rd, "R7", {it.tag, " read data"}, rdata, it.exp_rd);
                end
                busy_n = 0; rd_n_cnt = 0; wr_n_cnt = 0; ale_n = 0; addr_err = 0; lane_err = 0;
            end
            if (busy) busy_n++;
            if (!bus_rd_n) begin
                rd_n_cnt++;
                if (bus_ad_oe) lane_err++;
            end
            if (!bus_wr_n) begin
                wr_n_cnt++;
                if (q.size() > 0 && (!bus_ad_oe || bus_ad_out != q[0].wdata)) lane_err++;
            end
            if (bus_ale) begin
                ale_n++;
                if (q.size() > 0 && (!bus_ad_oe || {bus_addr_hi, bus_ad_out} != q[0].addr))
                    addr_err++;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done, "R2", "idle after reset", {busy, done}, 0);
        check(bus_rd_n && bus_wr_n && !bus_ale && !bus_ad_oe, "R2", "bus idle after reset",
              {bus_rd_n, bus_wr_n, bus_ale, bus_ad_oe}, 4'b1100);
        check(rdata == 8'h00, "R2", "rdata after reset", rdata, 0);

        // R2: defaults give a 12-clock external access even in the low window
        issue(0, 16'h0010, 8'h00, "R2 default read");
        issue(1, 16'h0020, 8'h5A, "R2 default write");
        issue(0, 16'h0020, 8'h00, "R8 readback");

        // R1/R3: sweep every stretch value
        for (int n = 0; n < 8; n++) begin
            set_cfg(n, 0);
            issue(1, 16'h1200 + 16'(n), 8'(8'h80 + n), "R1 sweep write");
            issue(0, 16'h1200 + 16'(n), 8'h00, "R1 sweep read");
        end

        // R5: internal window, long stretch has no effect
        set_cfg(7, 1);
        issue(1, 16'h0000, 8'h11, "R5 int write lo");
        issue(1, 16'h03FF, 8'h22, "R5 int write hi");
        issue(0, 16'h0000, 8'h00, "R5 int read lo");
        issue(0, 16'h03FF, 8'h00, "R5 int read hi");
        // R6: just above the window goes out
        issue(1, 16'h0400, 8'h33, "R6 ext write");
        issue(0, 16'h0400, 8'h00, "R6 ext read");
        issue(0, 16'hFFFF, 8'h00, "R6 top read");

        // R9: request raised mid-access is ignored
        issue(0, 16'h2000, 8'h00, "R9 carrier read");
        repeat (3) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0123; req_wdata = 8'hEE;
        @(negedge clk);
        req_valid = 1'b0;
        set_cfg(0, 0);
        issue(0, 16'h0123, 8'h00, "R9 untouched read");
        set_cfg(0, 1);
        issue(0, 16'h0123, 8'h00, "R9 untouched int read");

        // R10: config written on the accepting edge applies afterwards
        set_cfg(2, 1);
        issue(0, 16'h0000, 8'h00, "R10 old window", 1, 6, 0);
        issue(0, 16'h0000, 8'h00, "R10 new setting");
        issue(1, 16'h4444, 8'h77, "R10 old stretch", 1, 0, 0);
        issue(0, 16'h4444, 8'h00, "R10 new stretch");

        wait_idle();
        repeat (4) @(negedge clk);
        check(q.size() == 0, "R7", "all accesses completed", q.size(), 0);
        check(rdata == 8'h77, "R7", "rdata held after last done", rdata, 8'h77);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule